// File: doc/BRIEF.md
# Low-Power Mode Wake-up Controller

This block puts a small processor system into one of two low-power states and brings it back. Software picks a state by writing a one to a select bit of an 8-bit control register. In the light state (suspend) the block gates the system clock and tells every internal oscillator to stop. In the deep state (sleep) it also turns the core regulator off and freezes the digital output pins. The block runs on its own always-on clock, so it keeps working while the system clock is gated.

While the system is in a low-power state, the block watches five wake-up sources, each with its own enable. In suspend it also watches for a falling edge on the active-low reset pin. When one of these fires, the block restarts the clock and records the cause in sticky flag bits. For two cycles after a wake-up from suspend, the flags read back as zero. After leaving sleep, it pulls an active-low request line low so that outside devices can wake too. After a wake-up caused by the reset pin, a guard window of `GUARD_TICKS` low-frequency ticks starts. While it runs, suspend requests are ignored, so the reset logic has time to act.

The FSM has five states. In `ST_RUN` a register write is accepted. The transition enter-sleep or enter-suspend leaves `ST_RUN`. The transition source-wake leaves `ST_SUSPEND` or `ST_SLEEP` and goes to `ST_WAKE1`. After that, `ST_WAKE1` goes to `ST_WAKE2` and `ST_WAKE2` goes back to `ST_RUN`, one cycle each.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: If a register write with bit 6 set, and bit 7 clear, is accepted, then on the next cycle `sys_clk_en` is 0, `osc_dis` is 1 and `cfg_rdata[6]` reads 1. Writes are accepted only when `clk_src_ok` is 1, the block is running and no guard window is active.
- R2: If an accepted write has bit 7 set, the block enters sleep, whatever the value of bit 6. In sleep, `sys_clk_en` is 0, `osc_dis`, `vreg_off` and `io_hold` are 1, and `cfg_rdata[7]` reads 1.
- R3: Source bit k of `src_evt` has enable bit k of `wake_en`. The order is: 0 capacitive-sense conversion or scan done, 1 real-time-clock oscillator fail, 2 real-time-clock alarm, 3 port match, 4 comparator rising edge. An event whose enable is 1 wakes the block from suspend or sleep: `sys_clk_en` is 1 on the next cycle and flag bit k is set. An event whose enable is 0 has no effect.
- R4: In suspend, a falling edge on `rst_pin_n`, even a single cycle low, wakes the block and sets flag bit 5. In sleep the reset pin does not wake the block.
- R5: The flags `cfg_rdata[5:0]` are sticky. Any write made while running clears them. For the two cycles that follow a wake-up from suspend they read as 0, and after that they show their true value. After a wake-up from sleep they are never masked.
- R6: After a reset-pin wake-up, suspend requests are ignored until `GUARD_TICKS` pulses of `lf_tick` have passed. Sleep requests are still accepted during that time. A wake-up caused by any other source starts no guard window.
- R7: `wake_req_n` is 0 during the two cycles that follow a wake-up from sleep, and 1 at all other times.
- R8: A write made while `clk_src_ok` is 0 does not change state. It still clears the flags.
- R9: Bits 7 and 6 of the register read as 1 only while the block is in the matching low-power state. Hardware clears them on wake-up, and they are never both 1.
- R10: After reset, `sys_clk_en` and `wake_req_n` are 1, `osc_dis`, `vreg_off` and `io_hold` are 0, and `cfg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Write data; bit 7 selects sleep, bit 6 selects suspend |
| cfg_rdata | output | 8 | Read data: {sleep, suspend, flags[5:0]} |
| clk_src_ok | input | 1 | System clock source is one allowed for low-power entry |
| wake_en | input | NSRC | Per-source wake enables |
| src_evt | input | NSRC | Wake-up source event pulses |
| rst_pin_n | input | 1 | Synchronized level of the active-low reset pin |
| lf_tick | input | 1 | One-cycle pulse from the low-frequency time base |
| sys_clk_en | output | 1 | System clock gate enable |
| osc_dis | output | 1 | Disable for the internal oscillators |
| vreg_off | output | 1 | Core regulator off |
| io_hold | output | 1 | Freeze digital output pins |
| wake_req_n | output | 1 | Active-low wake request to external devices |

## Verification
The bench builds the block with `GUARD_TICKS` set to 3 and drives `lf_tick` once every four cycles. This makes the guard window about twelve cycles long. Both outcomes are then reachable in a short run: a suspend request blocked inside the window, and one accepted after it. A sleep request made inside the window can also be shown to succeed. `NSRC` keeps its default of 5, so the reset-pin flag sits at bit 5, next to the mode bits. A long stretch of random writes, events, enables and pin glitches is then compared cycle by cycle against a behavioural model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_SUSPEND,
        ST_SLEEP,
        ST_WAKE1,
        ST_WAKE2
    } lpm_state_t;
endpackage

// File: rtl/lpm_fall_det.sv
module lpm_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_n;
    end

    assign fall = prev_q & ~pin_n;
endmodule

// File: rtl/lpm_guard_timer.sv
module lpm_guard_timer #(
    parameter int TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic busy
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= CW'(TICKS);
        else if (tick && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
    import lpm_pkg::*;
#(
    parameter int NSRC        = 5,
    parameter int GUARD_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    input  logic            clk_src_ok,
    input  logic [NSRC-1:0] wake_en,
    input  logic [NSRC-1:0] src_evt,
    input  logic            rst_pin_n,
    input  logic            lf_tick,
    output logic            sys_clk_en,
    output logic            osc_dis,
    output logic            vreg_off,
    output logic            io_hold,
    output logic            wake_req_n
);
    localparam int FLAG_W    = NSRC + 1;
    localparam int SUSP_BIT  = 6;
    localparam int SLEEP_BIT = 7;

    lpm_state_t        state_q, state_d;
    logic [FLAG_W-1:0] flags_q, flags_d;
    logic              from_susp_q, from_susp_d;
    logic              pin_fall, guard_busy, guard_load;
    logic [NSRC-1:0]   hits;
    logic              flag_mask;
    logic              wdata_unused;

    assign hits         = src_evt & wake_en;
    assign wdata_unused = ^cfg_wdata[SUSP_BIT-1:0];

    lpm_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (rst_pin_n),
        .fall  (pin_fall)
    );

    lpm_guard_timer #(.TICKS(GUARD_TICKS)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (guard_load),
        .tick  (lf_tick),
        .busy  (guard_busy)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            flags_q     <= '0;
            from_susp_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            flags_q     <= flags_d;
            from_susp_q <= from_susp_d;
        end
    end

    // transitions
    always_comb begin
        state_d     = state_q;
        flags_d     = flags_q;
        from_susp_d = from_susp_q;
        guard_load  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (cfg_wr) begin
                    flags_d = '0;
                    if (clk_src_ok) begin
                        if (cfg_wdata[SLEEP_BIT])
                            state_d = ST_SLEEP;
                        else if (cfg_wdata[SUSP_BIT] && !guard_busy)
                            state_d = ST_SUSPEND;
                    end
                end
            end
            ST_SUSPEND: begin
                if ((|hits) || pin_fall) begin
                    flags_d     = flags_q | {pin_fall, hits};
                    from_susp_d = 1'b1;
                    guard_load  = pin_fall;
                    state_d     = ST_WAKE1;
                end
            end
            ST_SLEEP: begin
                if (|hits) begin
                    flags_d     = flags_q | {1'b0, hits};
                    from_susp_d = 1'b0;
                    state_d     = ST_WAKE1;
                end
            end
            ST_WAKE1: state_d = ST_WAKE2;
            ST_WAKE2: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        sys_clk_en = 1'b1;
        osc_dis    = 1'b0;
        vreg_off   = 1'b0;
        io_hold    = 1'b0;
        wake_req_n = 1'b1;
        flag_mask  = 1'b0;
        cfg_rdata  = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_SUSPEND: begin
                sys_clk_en          = 1'b0;
                osc_dis             = 1'b1;
                cfg_rdata[SUSP_BIT] = 1'b1;
            end
            ST_SLEEP: begin
                sys_clk_en           = 1'b0;
                osc_dis              = 1'b1;
                vreg_off             = 1'b1;
                io_hold              = 1'b1;
                cfg_rdata[SLEEP_BIT] = 1'b1;
            end
            ST_WAKE1, ST_WAKE2: begin
                flag_mask  = from_susp_q;
                wake_req_n = from_susp_q;
            end
            default: ;
        endcase
        cfg_rdata[FLAG_W-1:0] = flag_mask ? '0 : flags_q;
    end
endmodule

// File: rtl/lpm_wake_chk.sv
module lpm_wake_chk #(
    parameter int NSRC = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic [7:0]      cfg_wdata,
    input logic [7:0]      cfg_rdata,
    input logic            clk_src_ok,
    input logic [NSRC-1:0] wake_en,
    input logic [NSRC-1:0] src_evt,
    input logic            sys_clk_en,
    input logic            osc_dis,
    input logic            vreg_off,
    input logic            io_hold,
    input logic            wake_req_n,
    input logic            guard_busy
);
    localparam int FLAG_W = NSRC + 1;

    // R1
    suspend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6] |-> (!sys_clk_en && osc_dis && !vreg_off));

    // R2
    sleep_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] |-> (!sys_clk_en && osc_dis && vreg_off && io_hold));

    // R3
    enabled_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rdata[6] || cfg_rdata[7]) && ((src_evt & wake_en) != '0)) |=> sys_clk_en);

    // R5
    flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sys_clk_en) && $past(cfg_rdata[6])) |-> (cfg_rdata[FLAG_W-1:0] == '0));

    // R6
    guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sys_clk_en && guard_busy && !cfg_wdata[7]) |=> !cfg_rdata[6]);

    // R7
    wake_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_req_n |-> (sys_clk_en && !vreg_off && !io_hold));

    // R8
    src_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sys_clk_en && !clk_src_ok) |=> (!cfg_rdata[6] && !cfg_rdata[7]));

    // R9
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rdata[6] && cfg_rdata[7]));
endmodule

bind lpm_wake_ctrl lpm_wake_chk #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .clk_src_ok (clk_src_ok),
    .wake_en    (wake_en),
    .src_evt    (src_evt),
    .sys_clk_en (sys_clk_en),
    .osc_dis    (osc_dis),
    .vreg_off   (vreg_off),
    .io_hold    (io_hold),
    .wake_req_n (wake_req_n),
    .guard_busy (guard_busy)
);

// File: tb/lpm_wake_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_bench;
    localparam int NSRC = 5;
    localparam int GT   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 1'b0;
    logic [7:0]      cfg_wdata = 8'h00;
    logic [7:0]      cfg_rdata;
    logic            clk_src_ok = 1'b1;
    logic [NSRC-1:0] wake_en = '0;
    logic [NSRC-1:0] src_evt = '0;
    logic            rst_pin_n = 1'b1;
    logic            lf_tick = 1'b0;
    logic            sys_clk_en, osc_dis, vreg_off, io_hold, wake_req_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lpm_wake_ctrl #(.NSRC(NSRC), .GUARD_TICKS(GT)) u_lpm_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .clk_src_ok(clk_src_ok), .wake_en(wake_en),
        .src_evt(src_evt), .rst_pin_n(rst_pin_n), .lf_tick(lf_tick),
        .sys_clk_en(sys_clk_en), .osc_dis(osc_dis), .vreg_off(vreg_off),
        .io_hold(io_hold), .wake_req_n(wake_req_n)
    );

    // behavioural reference: 0 run, 1 suspend, 2 sleep, 3/4 the two wake cycles
    int       m_mode;
    int       m_guard;
    bit [5:0] m_flags;
    bit       m_susp_wake;
    bit       m_pin_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_guard = 0; m_flags = 0; m_susp_wake = 0; m_pin_prev = 1;
        end else begin
            int  nxt, ng;
            bit  edge_seen;
            bit [4:0] fired;
            edge_seen = m_pin_prev && !rst_pin_n;
            fired = src_evt & wake_en;
            nxt = m_mode;
            ng = m_guard;
            if (lf_tick && ng > 0) ng = ng - 1;
            if (m_mode == 0) begin
                if (cfg_wr) begin
                    m_flags = 0;
                    if (clk_src_ok) begin
                        if (cfg_wdata[7]) nxt = 2;
                        else if (cfg_wdata[6] && m_guard == 0) nxt = 1;
                    end
                end
            end else if (m_mode == 1) begin
                if (fired != 0 || edge_seen) begin
                    m_flags = m_flags | {edge_seen, fired};
                    m_susp_wake = 1;
                    if (edge_seen) ng = GT;
                    nxt = 3;
                end
            end else if (m_mode == 2) begin
                if (fired != 0) begin
                    m_flags = m_flags | {1'b0, fired};
                    m_susp_wake = 0;
                    nxt = 3;
                end
            end else if (m_mode == 3) nxt = 4;
            else nxt = 0;
            m_mode = nxt;
            m_guard = ng;
            m_pin_prev = rst_pin_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit low;
        bit masked;
        low = (m_mode == 1) || (m_mode == 2);
        masked = (m_mode >= 3) && m_susp_wake;
        chk("R1/R2 sys_clk_en", sys_clk_en, !low);
        chk("R1 osc_dis", osc_dis, low);
        chk("R2 vreg_off", vreg_off, m_mode == 2);
        chk("R2 io_hold", io_hold, m_mode == 2);
        chk("R7 wake_req_n", wake_req_n, !((m_mode >= 3) && !m_susp_wake));
        chk("R9 mode bits", cfg_rdata[7:6], {m_mode == 2, m_mode == 1});
        chk("R3/R4/R5 flags", cfg_rdata[5:0], masked ? 0 : m_flags);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0; cfg_wdata = 8'h00;
    endtask

    task automatic pulse(input logic [NSRC-1:0] e);
        src_evt = e;
        step(1);
        src_evt = '0;
    endtask

    task automatic pin_glitch();
        rst_pin_n = 1'b0;
        step(1);
        rst_pin_n = 1'b1;
    endtask

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 lf_tick = 1'b1;
            @(posedge clk);
            #1 lf_tick = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R10 reset sys_clk_en", sys_clk_en, 1);
        chk("R10 reset rdata", cfg_rdata, 0);
        chk("R10 reset wake_req_n", wake_req_n, 1);
        rst_n = 1'b1;
        step(2);

        // suspend, disabled event, enabled event, flag mask
        wake_en = 5'b00100;
        wr(8'h40);
        chk("R1 suspend entered", {sys_clk_en, osc_dis, cfg_rdata[6]}, 3'b011);
        pulse(5'b00001);
        chk("R3 disabled source ignored", sys_clk_en, 0);
        pulse(5'b00100);
        chk("R3 enabled source wakes", sys_clk_en, 1);
        chk("R5 flags masked wake1", cfg_rdata, 8'h00);
        step(1);
        chk("R5 flags masked wake2", cfg_rdata, 8'h00);
        step(1);
        chk("R5 R9 flag visible, mode clear", cfg_rdata, 8'h04);
        wr(8'h00);
        chk("R5 write clears flags", cfg_rdata, 8'h00);

        // sleep, reset pin ignored, wake request
        wake_en = 5'b10000;
        wr(8'h80);
        chk("R2 sleep entered", {vreg_off, io_hold, cfg_rdata[7]}, 3'b111);
        pin_glitch();
        step(1);
        chk("R4 reset pin ignored in sleep", sys_clk_en, 0);
        pulse(5'b10000);
        chk("R7 wake_req low 1", wake_req_n, 0);
        chk("R5 sleep wake not masked", cfg_rdata, 8'h10);
        step(1);
        chk("R7 wake_req low 2", wake_req_n, 0);
        step(1);
        chk("R7 wake_req released", wake_req_n, 1);

        // both bits: sleep wins
        wr(8'hC0);
        chk("R2 sleep has priority", cfg_rdata, 8'h80);
        pulse(5'b10000);
        step(3);

        // clock source not ready
        clk_src_ok = 1'b0;
        wr(8'h40);
        chk("R8 entry refused", {sys_clk_en, cfg_rdata[6]}, 2'b10);
        clk_src_ok = 1'b1;

        // reset pin wake and guard window
        wr(8'h40);
        pin_glitch();
        chk("R4 reset pin wakes", sys_clk_en, 1);
        step(2);
        chk("R4 reset pin flag", cfg_rdata, 8'h20);
        wr(8'h40);
        chk("R6 suspend blocked by guard", {sys_clk_en, cfg_rdata}, 9'h100);
        step(1);
        wr(8'h80);
        chk("R6 sleep allowed during guard", cfg_rdata[7], 1);
        wake_en = 5'b00011;
        pulse(5'b00010);
        step(2);
        wr(8'h40);
        chk("R6 suspend still blocked", cfg_rdata[6], 0);
        step(20);
        wr(8'h40);
        chk("R6 suspend after guard", cfg_rdata[6], 1);
        pulse(5'b00001);
        step(2);
        wr(8'h40);
        chk("R6 no guard after other source", cfg_rdata[6], 1);
        pulse(5'b00001);
        step(3);

        // random traffic against the model
        for (int i = 0; i < 1500; i++) begin
            if (i % 50 == 0) wake_en = NSRC'($urandom);
            cfg_wr     = ($urandom % 6 == 0);
            cfg_wdata  = 8'($urandom);
            clk_src_ok = ($urandom % 5 != 0);
            src_evt    = ($urandom % 7 == 0) ? NSRC'(1 << ($urandom % NSRC)) : '0;
            rst_pin_n  = ($urandom % 12 != 0);
            step(1);
        end
        cfg_wr = 1'b0; src_evt = '0; rst_pin_n = 1'b1;
        step(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule